// File: doc/BRIEF.md
# MESI Snoop State Controller

This block keeps the tag and MESI coherence state of every line of a direct-mapped write-back cache. Other bus masters present snoop requests carrying two attribute bits, an invalidate request and a non-cacheable-read hint. The block looks the address up, reports whether the line is held and in which state, and moves the line to its new state. When the snoop invalidates, it also sends a back-invalidation pulse toward the local processor. When the line was modified, it raises a write-back indication.

The block also judges processor writes. A write miss may request a line allocation only when it targets cacheable memory, is not locked, and has neither page cache-disable nor page write-through set. A fill port loads a tag and a state into a line once a linefill or other transfer completes. Data storage, bus transfers and replacement are handled elsewhere.

Top module: `mesi_snoop_unit`

## Requirements
- R1: A synchronous active-high reset sets every line to I and drives all registered outputs low, so a following snoop to any address misses.
- R2: A snoop reports its result on the cycle after it is presented, and only for that one cycle. On a hit to a valid line (state code S=1, E=2 or M=3), snpHit is high and snpFoundState gives the prior state. A snoop whose tag differs from the stored tag, or whose line is I (code 0), reports no outputs and changes no state.
- R3: A hit with the invalidate attribute set moves the line to I. It also raises backInval for exactly the one result cycle.
- R4: When both attributes are set, the invalidate attribute wins and the line moves to I.
- R5: A hit with invalidate clear and the non-cacheable-read attribute set moves an M or E line to E.
- R6: A hit with both attributes clear moves an M or E line to S.
- R7: A non-invalidating hit leaves an S line in S, whatever the non-cacheable-read attribute is.
- R8: A hit to an M line raises snpHitMod in the result cycle, for any attribute combination.
- R9: A processor write raises allocReq on the next cycle only when all of these hold: the write misses, cpuMemSpace=1, cpuLocked=0, cpuPageNoCache=0, cpuPageWrThru=0 and cpuCacheEnN=0. If any one of them fails, no request is made.
- R10: A snoop and a processor write presented in the same cycle are resolved in favour of the snoop. cpuStall is high in that cycle and no allocation results from it.
- R11: A fill with no snoop in the same cycle loads the line's tag and the given state code. A later snoop to that address reports that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| snpValid | input | 1 | Snoop request present |
| snpAddr | input | AW | Snoop address |
| snpInv | input | 1 | Snoop invalidate attribute |
| snpNonCacheRd | input | 1 | Requester performs a non-cacheable read |
| cpuWrValid | input | 1 | Processor write present |
| cpuWrAddr | input | AW | Processor write address |
| cpuCacheEnN | input | 1 | Cacheable enable, active low |
| cpuPageNoCache | input | 1 | Page cache-disable attribute |
| cpuPageWrThru | input | 1 | Page write-through attribute |
| cpuLocked | input | 1 | Locked write |
| cpuMemSpace | input | 1 | 1 = memory, 0 = I/O |
| fillValid | input | 1 | Load a line's tag and state |
| fillAddr | input | AW | Fill address |
| fillState | input | 2 | State code to load |
| snpHit | output | 1 | Snoop hit result |
| snpHitMod | output | 1 | Snoop hit a modified line; write-back needed |
| snpFoundState | output | 2 | Prior state of the snooped line |
| backInval | output | 1 | Back-invalidation pulse to the processor |
| cpuStall | output | 1 | Processor write held back by a snoop |
| allocReq | output | 1 | Line allocation request |

## Verification
A snoop and a processor write can fall in the same cycle. The bench provokes this by driving a qualifying write miss together with a snoop that hits a modified line. It judges the result by checking that cpuStall rises at once and that the snoop result appears while allocReq stays low. The same write, presented alone one cycle later, must then produce the allocation. This shows the stall did not consume or corrupt the write's qualification.

// File: rtl/mesi_snoop_pkg.sv
package mesi_snoop_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_E = 2'd2,
    LINE_M = 2'd3
  } lineState_t;

  // strobes from control to the array
  typedef struct packed {
    logic       snpWr;
    logic       fillWr;
    lineState_t newState;
  } arrayStrobe_t;

endpackage

// File: rtl/mesi_array.sv
module mesi_array
  import mesi_snoop_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LINES = 16,
  parameter int OFFW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] snpAddr,
  input  logic [AW-1:0] cpuAddr,
  input  logic [AW-1:0] fillAddr,
  input  arrayStrobe_t  strobe,
  output lineState_t    snpState,
  output logic          cpuHit
);
  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - OFFW - IDXW;

  logic [TAGW-1:0] tagArr   [LINES];
  lineState_t      stateArr [LINES];

  logic [IDXW-1:0] snpIdx, cpuIdx, fillIdx;
  logic [TAGW-1:0] snpTag, cpuTag, fillTag;
  logic [LINES-1:0] snpSel, fillSel;

  assign snpIdx  = snpAddr[OFFW +: IDXW];
  assign cpuIdx  = cpuAddr[OFFW +: IDXW];
  assign fillIdx = fillAddr[OFFW +: IDXW];
  assign snpTag  = snpAddr[AW-1 -: TAGW];
  assign cpuTag  = cpuAddr[AW-1 -: TAGW];
  assign fillTag = fillAddr[AW-1 -: TAGW];

  for (genvar i = 0; i < LINES; i++) begin : genSel
    assign snpSel[i]  = strobe.snpWr  && (snpIdx  == IDXW'(i));
    assign fillSel[i] = strobe.fillWr && (fillIdx == IDXW'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (rst) begin
        stateArr[i] <= LINE_I;
        tagArr[i]   <= '0;
      end else if (snpSel[i]) begin
        stateArr[i] <= strobe.newState;
      end else if (fillSel[i]) begin
        stateArr[i] <= strobe.newState;
        tagArr[i]   <= fillTag;
      end
    end
  end

  always_comb begin
    snpState = LINE_I;
    if (stateArr[snpIdx] != LINE_I && tagArr[snpIdx] == snpTag)
      snpState = stateArr[snpIdx];
    cpuHit = (stateArr[cpuIdx] != LINE_I) && (tagArr[cpuIdx] == cpuTag);
  end

endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_snoop_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         snpValid,
  input  logic         snpInv,
  input  logic         snpNonCacheRd,
  input  lineState_t   snpState,
  input  logic         cpuWrValid,
  input  logic         cpuHit,
  input  logic         cpuCacheEnN,
  input  logic         cpuPageNoCache,
  input  logic         cpuPageWrThru,
  input  logic         cpuLocked,
  input  logic         cpuMemSpace,
  input  logic         fillValid,
  input  logic [1:0]   fillState,
  output arrayStrobe_t strobe,
  output logic         cpuStall,
  output logic         snpHit,
  output logic         snpHitMod,
  output logic [1:0]   snpFoundState,
  output logic         backInval,
  output logic         allocReq
);
  logic       snpIsHit;
  lineState_t snpNext;
  logic       allocNext;

  always_comb begin
    snpIsHit = snpValid && (snpState != LINE_I);
    if (snpInv)                 snpNext = LINE_I;
    else if (snpState == LINE_S) snpNext = LINE_S;
    else if (snpNonCacheRd)     snpNext = LINE_E;
    else                        snpNext = LINE_S;

    strobe.snpWr    = snpIsHit;
    strobe.fillWr   = fillValid && !snpValid;
    strobe.newState = snpIsHit ? snpNext : lineState_t'(fillState);

    cpuStall  = cpuWrValid && snpValid;
    allocNext = cpuWrValid && !snpValid && !cpuHit && cpuMemSpace &&
                !cpuLocked && !cpuPageNoCache && !cpuPageWrThru && !cpuCacheEnN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snpHit        <= 1'b0;
      snpHitMod     <= 1'b0;
      snpFoundState <= 2'd0;
      backInval     <= 1'b0;
      allocReq      <= 1'b0;
    end else begin
      snpHit        <= snpIsHit;
      snpHitMod     <= snpIsHit && (snpState == LINE_M);
      snpFoundState <= snpValid ? snpState : LINE_I;
      backInval     <= snpIsHit && snpInv;
      allocReq      <= allocNext;
    end
  end

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_snoop_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LINES = 16,
  parameter int OFFW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snpValid,
  input  logic [AW-1:0] snpAddr,
  input  logic          snpInv,
  input  logic          snpNonCacheRd,
  input  logic          cpuWrValid,
  input  logic [AW-1:0] cpuWrAddr,
  input  logic          cpuCacheEnN,
  input  logic          cpuPageNoCache,
  input  logic          cpuPageWrThru,
  input  logic          cpuLocked,
  input  logic          cpuMemSpace,
  input  logic          fillValid,
  input  logic [AW-1:0] fillAddr,
  input  logic [1:0]    fillState,
  output logic          snpHit,
  output logic          snpHitMod,
  output logic [1:0]    snpFoundState,
  output logic          backInval,
  output logic          cpuStall,
  output logic          allocReq
);
  arrayStrobe_t strobe;
  lineState_t   snpState;
  logic         cpuHit;

  mesi_array #(.AW(AW), .LINES(LINES), .OFFW(OFFW)) u_array (
    .clk      (clk),
    .rst      (rst),
    .snpAddr  (snpAddr),
    .cpuAddr  (cpuWrAddr),
    .fillAddr (fillAddr),
    .strobe   (strobe),
    .snpState (snpState),
    .cpuHit   (cpuHit)
  );

  mesi_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .snpValid       (snpValid),
    .snpInv         (snpInv),
    .snpNonCacheRd  (snpNonCacheRd),
    .snpState       (snpState),
    .cpuWrValid     (cpuWrValid),
    .cpuHit         (cpuHit),
    .cpuCacheEnN    (cpuCacheEnN),
    .cpuPageNoCache (cpuPageNoCache),
    .cpuPageWrThru  (cpuPageWrThru),
    .cpuLocked      (cpuLocked),
    .cpuMemSpace    (cpuMemSpace),
    .fillValid      (fillValid),
    .fillState      (fillState),
    .strobe         (strobe),
    .cpuStall       (cpuStall),
    .snpHit         (snpHit),
    .snpHitMod      (snpHitMod),
    .snpFoundState  (snpFoundState),
    .backInval      (backInval),
    .allocReq       (allocReq)
  );

endmodule

// File: rtl/mesi_snoop_unit_chk.sv
module mesi_snoop_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       snpValid,
  input logic       snpInv,
  input logic       cpuWrValid,
  input logic       snpHit,
  input logic       snpHitMod,
  input logic [1:0] snpFoundState,
  input logic       backInval,
  input logic       cpuStall,
  input logic       allocReq
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!snpHit && !allocReq && !backInval));

  // R2
  hit_needs_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    snpHit |-> $past(snpValid));

  // R3
  inval_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (snpHit && $past(snpInv)) |-> backInval);

  // R3
  inval_cause_chk: assert property (@(posedge clk) disable iff (rst)
    backInval |-> (snpHit && $past(snpInv && snpValid)));

  // R8
  hitmod_state_chk: assert property (@(posedge clk) disable iff (rst)
    snpHitMod |-> (snpHit && snpFoundState == 2'd3));

  // R10
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cpuStall |-> (snpValid && cpuWrValid));

  // R10
  stall_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    cpuStall |=> !allocReq);

endmodule

bind mesi_snoop_unit mesi_snoop_unit_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .snpValid      (snpValid),
  .snpInv        (snpInv),
  .cpuWrValid    (cpuWrValid),
  .snpHit        (snpHit),
  .snpHitMod     (snpHitMod),
  .snpFoundState (snpFoundState),
  .backInval     (backInval),
  .cpuStall      (cpuStall),
  .allocReq      (allocReq)
);

// File: tb/test_mesi_snoop_unit.sv
`timescale 1ns/1ps
module test_mesi_snoop_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic snpValid = 0, snpInv = 0, snpNonCacheRd = 0;
  logic [15:0] snpAddr = '0, cpuWrAddr = '0, fillAddr = '0;
  logic cpuWrValid = 0, cpuCacheEnN = 1, cpuPageNoCache = 0, cpuPageWrThru = 0;
  logic cpuLocked = 0, cpuMemSpace = 1, fillValid = 0;
  logic [1:0] fillState = '0;
  logic snpHit, snpHitMod, backInval, cpuStall, allocReq;
  logic [1:0] snpFoundState;

  always #2.5 clk = ~clk;

  mesi_snoop_unit i_mesi_snoop_unit (.*);

  typedef struct {
    logic       hit, hitMod, binv, alloc;
    logic [1:0] st;
    string      req;
  } exp_t;

  exp_t expQ[$];
  int checks = 0, fails = 0;
  logic [1:0] mSt [16];
  logic [6:0] mTag [16];

  function automatic logic [15:0] mk(input logic [6:0] t, input logic [3:0] i);
    return {t, i, 5'b0};
  endfunction

  function automatic logic [1:0] found(input logic [15:0] a);
    if (mSt[a[8:5]] != 2'd0 && mTag[a[8:5]] == a[15:9]) return mSt[a[8:5]];
    return 2'd0;
  endfunction

  task automatic clearIn();
    snpValid = 0; snpInv = 0; snpNonCacheRd = 0; cpuWrValid = 0; fillValid = 0;
    cpuCacheEnN = 1; cpuPageNoCache = 0; cpuPageWrThru = 0; cpuLocked = 0; cpuMemSpace = 1;
  endtask

  task automatic push(input logic h, hm, bi, al, input logic [1:0] s, input string r);
    exp_t e;
    e.hit = h; e.hitMod = hm; e.binv = bi; e.alloc = al; e.st = s; e.req = r;
    expQ.push_back(e);
  endtask

  // model update of a snoop, from the requirements
  task automatic snoopModel(input logic [15:0] a, input logic inv, nca, input string r);
    logic [1:0] f;
    f = found(a);
    push(f != 0, f == 2'd3, (f != 0) && inv, 1'b0, f, r);
    if (f != 0) begin
      if (inv) mSt[a[8:5]] = 2'd0;
      else if (f == 2'd1) mSt[a[8:5]] = 2'd1;
      else if (nca) mSt[a[8:5]] = 2'd2;
      else mSt[a[8:5]] = 2'd1;
    end
  endtask

  task automatic snoop(input logic [15:0] a, input logic inv, nca, input string r);
    @(negedge clk); clearIn();
    snpValid = 1; snpAddr = a; snpInv = inv; snpNonCacheRd = nca;
    snoopModel(a, inv, nca, r);
  endtask

  task automatic fill(input logic [15:0] a, input logic [1:0] s);
    @(negedge clk); clearIn();
    fillValid = 1; fillAddr = a; fillState = s;
    mSt[a[8:5]] = s; mTag[a[8:5]] = a[15:9];
    push(0, 0, 0, 0, 2'd0, "R11");
  endtask

  task automatic cpuWr(input logic [15:0] a, input logic enN, pcd, pwt, lck, mem, input string r);
    logic h;
    @(negedge clk); clearIn();
    cpuWrValid = 1; cpuWrAddr = a; cpuCacheEnN = enN; cpuPageNoCache = pcd;
    cpuPageWrThru = pwt; cpuLocked = lck; cpuMemSpace = mem;
    h = found(a) != 0;
    push(0, 0, 0, !h && mem && !lck && !pcd && !pwt && !enN, 2'd0, r);
  endtask

  task automatic collide(input logic [15:0] sa, input logic [15:0] ca);
    @(negedge clk); clearIn();
    snpValid = 1; snpAddr = sa;
    cpuWrValid = 1; cpuWrAddr = ca; cpuCacheEnN = 0;
    snoopModel(sa, 1'b0, 1'b0, "R10");
    #0.5;
    checks++;
    if (cpuStall !== 1'b1) begin
      fails++;
      $display("FAIL R10 cpuStall actual=%b expected=1", cpuStall);
    end
  endtask

  task automatic idle();
    @(negedge clk); clearIn();
    push(0, 0, 0, 0, 2'd0, "R2");
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (!rst && expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (snpHit !== e.hit || snpHitMod !== e.hitMod || backInval !== e.binv ||
          allocReq !== e.alloc || snpFoundState !== e.st) begin
        fails++;
        $display("FAIL %s actual hit=%b mod=%b st=%0d binv=%b alloc=%b expected hit=%b mod=%b st=%0d binv=%b alloc=%b",
                 e.req, snpHit, snpHitMod, snpFoundState, backInval, allocReq,
                 e.hit, e.hitMod, e.st, e.binv, e.alloc);
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mSt[i] = 0; mTag[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    checks++;  // R1 reset state
    if (snpHit !== 0 || allocReq !== 0 || backInval !== 0 || snpHitMod !== 0) begin
      fails++;
      $display("FAIL R1 actual outputs=%b%b%b%b expected=0000", snpHit, snpHitMod, backInval, allocReq);
    end
    // R1: all lines invalid after reset
    snoop(mk(7'd0, 4'd0), 0, 0, "R1");
    snoop(mk(7'd5, 4'd9), 0, 1, "R1");
    // R11: load lines
    fill(mk(7'd10, 4'd0), 2'd3);
    fill(mk(7'd11, 4'd1), 2'd2);
    fill(mk(7'd12, 4'd2), 2'd1);
    fill(mk(7'd13, 4'd3), 2'd3);
    fill(mk(7'd14, 4'd4), 2'd2);
    fill(mk(7'd15, 4'd5), 2'd3);
    // R6 R8: M to S
    snoop(mk(7'd10, 4'd0), 0, 0, "R6");
    snoop(mk(7'd10, 4'd0), 0, 0, "R6");
    // R7: S stays S
    snoop(mk(7'd12, 4'd2), 0, 1, "R7");
    snoop(mk(7'd12, 4'd2), 0, 0, "R7");
    snoop(mk(7'd12, 4'd2), 0, 0, "R7");
    // R5: E and M to E
    snoop(mk(7'd11, 4'd1), 0, 1, "R5");
    snoop(mk(7'd11, 4'd1), 0, 0, "R5");
    snoop(mk(7'd13, 4'd3), 0, 1, "R5");
    snoop(mk(7'd13, 4'd3), 0, 1, "R5");
    // R4: both attributes, invalidate wins
    snoop(mk(7'd14, 4'd4), 1, 1, "R4");
    snoop(mk(7'd14, 4'd4), 0, 0, "R4");
    // R3 R8: invalidate an M line
    snoop(mk(7'd15, 4'd5), 1, 0, "R3");
    idle();
    snoop(mk(7'd15, 4'd5), 0, 0, "R3");
    // R2: tag mismatch misses, leaves state
    snoop(mk(7'd99, 4'd0), 1, 0, "R2");
    snoop(mk(7'd10, 4'd0), 0, 1, "R2");
    // R9: allocation qualification
    cpuWr(mk(7'd40, 4'd7), 0, 0, 0, 0, 1, "R9");
    cpuWr(mk(7'd40, 4'd7), 1, 0, 0, 0, 1, "R9");
    cpuWr(mk(7'd40, 4'd7), 0, 1, 0, 0, 1, "R9");
    cpuWr(mk(7'd40, 4'd7), 0, 0, 1, 0, 1, "R9");
    cpuWr(mk(7'd40, 4'd7), 0, 0, 0, 1, 1, "R9");
    cpuWr(mk(7'd40, 4'd7), 0, 0, 0, 0, 0, "R9");
    cpuWr(mk(7'd10, 4'd0), 0, 0, 0, 0, 1, "R9");
    // R10: collision, then write alone
    fill(mk(7'd20, 4'd6), 2'd3);
    collide(mk(7'd20, 4'd6), mk(7'd41, 4'd8));
    cpuWr(mk(7'd41, 4'd8), 0, 0, 0, 0, 1, "R10");
    snoop(mk(7'd20, 4'd6), 0, 0, "R10");
    idle();
    @(negedge clk); clearIn();
    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule